// File: doc/BRIEF.md
# Host Interrupt Status Controller

This block collects the event sources of a USB host controller into one 8-bit interrupt status register and drives a single active-high interrupt request. A transfer-completion pulse from either of the two ping-pong transfer register sets, the frame timer tick, a device attach/detach pulse and a resume pulse each set a sticky status bit on their rising edge. An 8-bit enable register masks the bits onto the interrupt line. The CPU reads status and clears bits by writing ones to them.

One status bit has two meanings. A control input selects whether that bit is a sticky resume event or a live copy of the device-present level. A second bit is not an event at all: it mirrors the speed of the attached device. Neither level-type view can raise the interrupt. Register address decode and the event sources sit outside this block.

Top module: `host_irq_status`

## Requirements
- R1: After reset every sticky status bit, every enable bit and `irq` are 0.
- R2: A 0-to-1 transition seen at a clock edge on `evt_done_a`, `evt_done_b`, `evt_frame` or `evt_attach` sets status bit 0, 1, 4 or 5 respectively. The bit is visible after that edge. An input held high does not set the bit again once it has been cleared.
- R3: A status write with bit i of `st_wdata` equal to 1 clears sticky bit i at the edge. A 0 in that position leaves the bit unchanged.
- R4: When a rising event and a write-1 clear hit the same bit at the same edge, the bit ends up set.
- R5: With `resume_mode` = 1, status bit 6 is a sticky bit set by a rising edge of `evt_resume` and cleared by writing 1. With `resume_mode` = 0, bit 6 reads `dev_present` (1 = present), the sticky resume bit is cleared, and resume edges are ignored.
- R6: Status bit 7 always reads `dev_full_speed` (0 = low speed, 1 = full speed). Writes do not change it and it never drives `irq`.
- R7: Status bits 2 and 3 read 0. Enable bits 2 and 3 read 0 whatever is written to them.
- R8: `irq` is 1 exactly when some sticky bit among 0, 1, 4, 5, or bit 6 in resume mode, is set while its enable bit is 1. It follows status and enable without extra delay.
- R9: An enable write stores `en_wdata` (reserved bits forced to 0) at the edge, and `en_rdata` returns it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_done_a | input | 1 | Transfer done, register set A |
| evt_done_b | input | 1 | Transfer done, register set B |
| evt_frame | input | 1 | Frame timer tick |
| evt_attach | input | 1 | Device inserted or removed |
| evt_resume | input | 1 | Resume detected |
| dev_present | input | 1 | Device-present level |
| dev_full_speed | input | 1 | Attached device speed, 1 = full |
| resume_mode | input | 1 | Control bit selecting resume view of bit 6 |
| en_wr | input | 1 | Enable register write strobe |
| en_wdata | input | 8 | Enable register write data |
| st_wr | input | 1 | Status write-1-to-clear strobe |
| st_wdata | input | 8 | Status clear mask |
| en_rdata | output | 8 | Enable register contents |
| st_rdata | output | 8 | Status register view |
| irq | output | 1 | Active-high interrupt request |

## Verification
The first set of tests is directed. Single pulses on each source show that the bits are independent. A long-held event after a clear separates edge capture from level capture. Same-edge set and clear shows which one has priority. Toggling `resume_mode` shows the two views of bit 6, and driving the speed input while writing ones shows that bit 7 ignores writes. A seeded random phase then mixes pulses, clears, enable writes and mode flips. It is checked every cycle against a bench model, which brings out interactions between masking and clearing that the directed cases do not reach.

// File: rtl/host_irq_pkg.sv
package host_irq_pkg;
  localparam int STAT_W = 8;

  localparam int B_DONE_A = 0;
  localparam int B_DONE_B = 1;
  localparam int B_FRAME  = 4;
  localparam int B_ATTACH = 5;
  localparam int B_SHARED = 6;
  localparam int B_SPEED  = 7;

  typedef logic [STAT_W-1:0] stat_t;

  localparam stat_t EVT_MASK  = stat_t'((1 << B_DONE_A) | (1 << B_DONE_B) |
                                        (1 << B_FRAME)  | (1 << B_ATTACH));
  localparam stat_t LAT_MASK  = EVT_MASK | stat_t'(1 << B_SHARED);
  localparam stat_t RESV_MASK = stat_t'((1 << 2) | (1 << 3));

  // Sticky update: set has priority over clear.
  function automatic stat_t sticky_next(stat_t cur, stat_t set, stat_t clr);
    return set | (cur & ~clr);
  endfunction

  // Bits allowed to raise the interrupt in the current mode.
  function automatic stat_t irq_eligible(logic res_mode);
    return EVT_MASK | (res_mode ? stat_t'(1 << B_SHARED) : stat_t'(0));
  endfunction

  // Build the CPU-visible status view.
  function automatic stat_t status_view(stat_t lat, logic res_mode,
                                        logic present, logic fs);
    stat_t v;
    v = lat & EVT_MASK;
    v[B_SHARED] = res_mode ? lat[B_SHARED] : present;
    v[B_SPEED]  = fs;
    return v;
  endfunction
endpackage

// File: rtl/hirq_edge_bank.sv
module hirq_edge_bank #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl_i,
  output logic [W-1:0] rise_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic prev_q;
    always_ff @(posedge clk) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= lvl_i[i];
    end
    assign rise_o[i] = lvl_i[i] & ~prev_q;
  end
endmodule

// File: rtl/hirq_latch_bank.sv
module hirq_latch_bank
  import host_irq_pkg::*;
#(
  parameter stat_t KEEP = LAT_MASK
) (
  input  logic  clk,
  input  logic  rst_n,
  input  stat_t set_i,
  input  stat_t clr_i,
  input  stat_t flush_i,
  output stat_t lat_o
);
  stat_t lat_q;
  always_ff @(posedge clk) begin
    if (!rst_n) lat_q <= '0;
    else        lat_q <= sticky_next(lat_q, set_i, clr_i) & ~flush_i & KEEP;
  end
  assign lat_o = lat_q;
endmodule

// File: rtl/hirq_irq_gen.sv
module hirq_irq_gen
  import host_irq_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  en_wr,
  input  stat_t en_wdata,
  input  stat_t lat_i,
  input  logic  res_mode,
  output stat_t en_o,
  output logic  irq_o
);
  stat_t en_q;
  always_ff @(posedge clk) begin
    if (!rst_n)     en_q <= '0;
    else if (en_wr) en_q <= en_wdata & ~RESV_MASK;
  end
  assign en_o  = en_q;
  assign irq_o = |(lat_i & en_q & irq_eligible(res_mode));
endmodule

// File: rtl/host_irq_status.sv
module host_irq_status
  import host_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       evt_done_a,
  input  logic       evt_done_b,
  input  logic       evt_frame,
  input  logic       evt_attach,
  input  logic       evt_resume,
  input  logic       dev_present,
  input  logic       dev_full_speed,
  input  logic       resume_mode,
  input  logic       en_wr,
  input  logic [7:0] en_wdata,
  input  logic       st_wr,
  input  logic [7:0] st_wdata,
  output logic [7:0] en_rdata,
  output logic [7:0] st_rdata,
  output logic       irq
);
  stat_t evt_vec, rise_vec, set_vec, clr_vec, flush_vec, lat_vec;

  always_comb begin
    evt_vec = '0;
    evt_vec[B_DONE_A] = evt_done_a;
    evt_vec[B_DONE_B] = evt_done_b;
    evt_vec[B_FRAME]  = evt_frame;
    evt_vec[B_ATTACH] = evt_attach;
    evt_vec[B_SHARED] = evt_resume;
  end

  hirq_edge_bank #(.W(STAT_W)) edge_i (
    .clk(clk), .rst_n(rst_n), .lvl_i(evt_vec), .rise_o(rise_vec)
  );

  always_comb begin
    set_vec = rise_vec & irq_eligible(resume_mode);
    clr_vec = st_wr ? st_wdata : '0;
    flush_vec = '0;
    flush_vec[B_SHARED] = ~resume_mode;
  end

  hirq_latch_bank #(.KEEP(LAT_MASK)) lat_i (
    .clk(clk), .rst_n(rst_n), .set_i(set_vec), .clr_i(clr_vec),
    .flush_i(flush_vec), .lat_o(lat_vec)
  );

  hirq_irq_gen irq_i (
    .clk(clk), .rst_n(rst_n), .en_wr(en_wr), .en_wdata(en_wdata),
    .lat_i(lat_vec), .res_mode(resume_mode), .en_o(en_rdata), .irq_o(irq)
  );

  assign st_rdata = status_view(lat_vec, resume_mode, dev_present, dev_full_speed);
endmodule

// File: rtl/host_irq_status_chk.sv
module host_irq_status_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       resume_mode,
  input logic       dev_present,
  input logic       dev_full_speed,
  input logic       st_wr,
  input logic [7:0] st_wdata,
  input logic [7:0] en_rdata,
  input logic [7:0] st_rdata,
  input logic       irq,
  input logic [7:0] rise_vec,
  input logic [7:0] lat_vec
);
  AST_RESV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (st_rdata[3:2] == 2'b00) && (en_rdata[3:2] == 2'b00)); // R7
  AST_SPEED_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
    st_rdata[7] == dev_full_speed); // R6
  AST_PRESENCE_VIEW: assert property (@(posedge clk) disable iff (!rst_n)
    !resume_mode |-> st_rdata[6] == dev_present); // R5
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(rise_vec) & 8'h33) & ~lat_vec) == 8'h00)); // R4
  AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((lat_vec & ~$past(lat_vec) & ~$past(rise_vec)) == 8'h00)); // R2
  AST_CLEAR_DONE_A: assert property (@(posedge clk) disable iff (!rst_n)
    (st_wr && st_wdata[0] && !rise_vec[0]) |=> !lat_vec[0]); // R3
  AST_NO_ENABLE_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (en_rdata == 8'h00) |-> !irq); // R8
endmodule

bind host_irq_status host_irq_status_chk chk_i (
  .clk(clk), .rst_n(rst_n), .resume_mode(resume_mode), .dev_present(dev_present),
  .dev_full_speed(dev_full_speed), .st_wr(st_wr), .st_wdata(st_wdata),
  .en_rdata(en_rdata), .st_rdata(st_rdata), .irq(irq),
  .rise_vec(rise_vec), .lat_vec(lat_vec)
);

// File: tb/host_irq_status_tb_top.sv
`timescale 1ns/1ps
module host_irq_status_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic done_a = 0, done_b = 0, frame = 0, attach = 0, resume = 0;
  logic present = 0, fs = 0, rmode = 0;
  logic en_wr = 0, st_wr = 0;
  logic [7:0] en_wdata = 0, st_wdata = 0;
  logic [7:0] en_rdata, st_rdata;
  logic irq;

  int checks = 0;
  int errors = 0;
  bit done_flag = 0;

  // bench model state
  logic [7:0] m_lat = 0, m_prev = 0, m_en = 0;

  always #4 clk = ~clk;

  host_irq_status dut_i (
    .clk(clk), .rst_n(rst_n), .evt_done_a(done_a), .evt_done_b(done_b),
    .evt_frame(frame), .evt_attach(attach), .evt_resume(resume),
    .dev_present(present), .dev_full_speed(fs), .resume_mode(rmode),
    .en_wr(en_wr), .en_wdata(en_wdata), .st_wr(st_wr), .st_wdata(st_wdata),
    .en_rdata(en_rdata), .st_rdata(st_rdata), .irq(irq)
  );

  function automatic logic [7:0] ev_pack();
    return {1'b0, resume, attach, frame, 2'b00, done_b, done_a};
  endfunction

  function automatic logic [7:0] exp_status();
    logic [7:0] s;
    s = m_lat & 8'h33;
    s[6] = rmode ? m_lat[6] : present;
    s[7] = fs;
    return s;
  endfunction

  function automatic logic exp_irq();
    logic [7:0] elig;
    elig = rmode ? 8'h73 : 8'h33;
    return (m_lat & m_en & elig) != 8'h00;
  endfunction

  task automatic model_edge();
    logic [7:0] ev, rise, clr;
    ev = ev_pack();
    if (!rst_n) begin
      m_lat = 0; m_prev = 0; m_en = 0;
    end else begin
      rise = ev & ~m_prev;
      m_prev = ev;
      clr = st_wr ? st_wdata : 8'h00;
      for (int b = 0; b < 8; b++) begin
        if (b == 0 || b == 1 || b == 4 || b == 5)
          m_lat[b] = rise[b] | (m_lat[b] & ~clr[b]);
        else if (b == 6)
          m_lat[b] = rmode ? (rise[b] | (m_lat[b] & ~clr[b])) : 1'b0;
        else
          m_lat[b] = 1'b0;
      end
      if (en_wr) m_en = en_wdata & 8'hF3;
    end
  endtask

  task automatic check8(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  // one cycle: inputs already driven; clock, update model, compare at negedge
  task automatic step(string tag);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check8({tag, " status"}, st_rdata, exp_status());
    check8({tag, " enable R9"}, en_rdata, m_en);
    check8({"R8 irq ", tag}, {7'd0, irq}, {7'd0, exp_irq()});
  endtask

  task automatic idle_inputs();
    {done_a, done_b, frame, attach, resume} = '0;
    en_wr = 0; st_wr = 0; en_wdata = 0; st_wdata = 0;
  endtask

  task automatic clear_all();
    st_wr = 1; st_wdata = 8'hFF; step("R3 clear-all"); idle_inputs();
  endtask

  initial begin
    #200000;
    if (!done_flag) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    idle_inputs();
    rst_n = 0;
    repeat (3) @(negedge clk);
    step("R1 reset");
    rst_n = 1;
    step("R1 after reset");
    check8("R1 irq idle", {7'd0, irq}, 8'h00);

    // R9 / R7: enable write, reserved forced zero
    en_wr = 1; en_wdata = 8'hFF; step("R9 R7 enable all"); idle_inputs();
    check8("R7 enable reserved", en_rdata & 8'h0C, 8'h00);

    // R2: each source independently
    done_a = 1; step("R2 done_a"); idle_inputs(); step("R2 idle");
    check8("R2 bit0 set", st_rdata & 8'h33, 8'h01);
    clear_all();
    done_b = 1; step("R2 done_b"); idle_inputs();
    frame = 1; step("R2 frame"); idle_inputs();
    attach = 1; step("R2 attach"); idle_inputs(); step("R2 idle2");
    check8("R2 bits 1,4,5", st_rdata & 8'h33, 8'h32);

    // R3: writing zero keeps, writing one clears only that bit
    st_wr = 1; st_wdata = 8'h00; step("R3 write zero"); idle_inputs();
    check8("R3 kept", st_rdata & 8'h33, 8'h32);
    st_wr = 1; st_wdata = 8'h10; step("R3 clear frame"); idle_inputs();
    check8("R3 frame cleared", st_rdata & 8'h33, 8'h22);
    clear_all();

    // R2: held level does not re-set after clear
    attach = 1; step("R2 hold rise");
    st_wr = 1; st_wdata = 8'h20; step("R2 hold clear"); st_wr = 0; st_wdata = 0;
    step("R2 hold"); step("R2 hold more");
    check8("R2 no re-set while held", st_rdata & 8'h20, 8'h00);
    idle_inputs(); step("R2 release");

    // R4: set and clear at the same edge
    done_a = 1; st_wr = 1; st_wdata = 8'h01; step("R4 collide"); idle_inputs();
    check8("R4 set wins", st_rdata & 8'h01, 8'h01);
    clear_all();

    // R5: shared bit modes
    rmode = 0; present = 1; resume = 1; step("R5 presence"); idle_inputs();
    check8("R5 presence view", st_rdata & 8'h40, 8'h40);
    check8("R5 presence no irq", {7'd0, irq}, 8'h00);
    present = 0; step("R5 presence low");
    check8("R5 presence follows", st_rdata & 8'h40, 8'h00);
    rmode = 1; step("R5 switch"); resume = 1; step("R5 resume"); idle_inputs();
    check8("R5 resume latched", st_rdata & 8'h40, 8'h40);
    check8("R8 resume irq", {7'd0, irq}, 8'h01);
    rmode = 0; step("R5 leave mode"); rmode = 1; step("R5 back");
    check8("R5 latch flushed", st_rdata & 8'h40, 8'h00);

    // R6: speed mirror, writes ignored, no irq
    fs = 1; st_wr = 1; st_wdata = 8'h80; step("R6 speed"); idle_inputs();
    check8("R6 speed bit", st_rdata & 8'h80, 8'h80);
    check8("R6 no irq", {7'd0, irq}, 8'h00);
    fs = 0; step("R6 speed low");

    // R8: masked event raises no irq
    en_wr = 1; en_wdata = 8'h01; step("R8 en bit0"); idle_inputs();
    done_b = 1; step("R8 masked"); idle_inputs();
    check8("R8 masked irq", {7'd0, irq}, 8'h00);
    done_a = 1; step("R8 unmasked"); idle_inputs();
    check8("R8 unmasked irq", {7'd0, irq}, 8'h01);
    clear_all();

    // random phase
    void'($urandom(32'd1234));
    for (int i = 0; i < 2000; i++) begin
      done_a = ($urandom % 4) == 0; done_b = ($urandom % 4) == 0;
      frame = ($urandom % 5) == 0; attach = ($urandom % 6) == 0;
      resume = ($urandom % 5) == 0; present = $urandom % 2;
      fs = $urandom % 2;
      if (($urandom % 16) == 0) rmode = ~rmode;
      en_wr = ($urandom % 8) == 0; en_wdata = 8'($urandom);
      st_wr = ($urandom % 3) == 0; st_wdata = 8'($urandom);
      step("R2 R3 R4 R5 R6 R7 random");
    end

    done_flag = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule